// File: doc/BRIEF.md
# Carry-Chained Slice ALU

This block is a 16-bit arithmetic and logic unit for an accumulator machine. The first operand is always the accumulator, and the second operand is a general register. The datapath is not one wide adder. It is a row of identical 4-bit slices, and the carry of each slice feeds the next slice up.

The result is combinational. It follows the accumulator, the register operand and the operation code in the same cycle. Carry, zero and sign are held in a small flag register. That register loads on a rising clock edge only while the flag-enable input is high. The carry flag is visible to the programmer: two operation codes force it to one or to zero and change nothing else.

Slice width and slice count are parameters, and the data width is their product. Opcode values: 0 ADD, 1 SUB, 2 INC, 3 DEC, 4 COM, 5 AND, 6 OR, 7 XOR, 8 SRA, 9 SLA, 10 STC (set carry), 11 CLC (clear carry). Codes 12 to 15 are reserved.

Top module: `cascade_alu`

## Requirements
- R1: Opcode 0 gives result = (A + B) mod 2^16. On an enabled edge, carry takes the carry out of bit 15.
- R2: Opcode 1 gives result = A + ~B + 1 (mod 2^16). Carry takes the carry out of bit 15, so it is 1 exactly when A >= B (no borrow).
- R3: Opcode 2 gives A + 1 and opcode 3 gives A + 0xFFFF (that is, A - 1). Both act on the accumulator, and carry takes the carry out: INC sets it only for A = 0xFFFF, and DEC clears it only for A = 0.
- R4: Opcodes 5, 6 and 7 give A AND B, A OR B and A XOR B. Opcode 4 gives ~A. All four leave the carry flag unchanged.
- R5: Opcode 8 gives {A[15], A[15:1]}. On an enabled edge, carry takes A[0].
- R6: Opcode 9 gives {A[14:0], 0}. On an enabled edge, carry takes A[15].
- R7: Opcode 10 loads carry with 1 and opcode 11 loads carry with 0. Both output result = A and leave zero and sign unchanged.
- R8: Every opcode from 0 to 9 loads the zero flag with (result == 0) and the sign flag with result bit 15.
- R9: When flag enable is low at a rising edge, carry, zero and sign all hold their values, whatever the opcode.
- R10: Reserved opcodes 12 to 15 output result = A and change no flag.
- R11: A synchronous active-low reset clears carry, zero and sign to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_i | input | 4 | Operation code |
| acc_i | input | 16 | Accumulator operand A |
| reg_i | input | 16 | Register operand B |
| flag_en_i | input | 1 | Allows the flags to load at the next edge |
| result_o | output | 16 | Combinational result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |

## Verification
The bench builds the block with its default parameters: four slices of four bits each. With this build, one short set of operands sends a carry across every slice boundary. For example, 0xFFFF + 1 and 0x0FFF + 1 reach both the top carry and the inner ripple paths, and subtraction with equal operands reaches the no-borrow edge. The bench also places shift and carry commands between flag-setting operations, so it can see whether each flag is held or loaded.

// File: rtl/cascade_alu_pkg.sv
package cascade_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_INC = 4'd2,
      OP_DEC = 4'd3,
      OP_COM = 4'd4,
      OP_AND = 4'd5,
      OP_OR  = 4'd6,
      OP_XOR = 4'd7,
      OP_SRA = 4'd8,
      OP_SLA = 4'd9,
      OP_STC = 4'd10,
      OP_CLC = 4'd11
   } alu_op_e;

   typedef enum logic [2:0] {
      FN_SUM,
      FN_AND,
      FN_OR,
      FN_XOR,
      FN_NOT
   } slice_fn_e;

   typedef enum logic [1:0] {
      SEL_SLICE,
      SEL_SRA,
      SEL_SLA,
      SEL_PASS
   } res_sel_e;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
   import cascade_alu_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  slice_fn_e    fn_i,
   output logic [W-1:0] f_o,
   output logic         cout_o
);

   logic [W:0]   chain;
   logic [W-1:0] sum;

   assign chain[0] = cin_i;

   // Bit-level ripple inside the slice
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a_i[i] ^ b_i[i] ^ chain[i];
      assign chain[i+1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
   end

   assign cout_o = chain[W];

   always_comb begin
      case (fn_i)
         FN_SUM:  f_o = sum;
         FN_AND:  f_o = a_i & b_i;
         FN_OR:   f_o = a_i | b_i;
         FN_XOR:  f_o = a_i ^ b_i;
         FN_NOT:  f_o = ~a_i;
         default: f_o = sum;
      endcase
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   output logic [DATA_W-1:0] sra_o,
   output logic [DATA_W-1:0] sla_o,
   output logic              sra_out_o,
   output logic              sla_out_o
);

   assign sra_o     = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
   assign sla_o     = {a_i[DATA_W-2:0], 1'b0};
   assign sra_out_o = a_i[0];
   assign sla_out_o = a_i[DATA_W-1];

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic upd_c_i,
   input  logic upd_zs_i,
   input  logic c_next_i,
   input  logic z_next_i,
   input  logic s_next_i,
   output logic c_o,
   output logic z_o,
   output logic s_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_o <= 1'b0;
         z_o <= 1'b0;
         s_o <= 1'b0;
      end else if (en_i) begin
         if (upd_c_i) c_o <= c_next_i;
         if (upd_zs_i) begin
            z_o <= z_next_i;
            s_o <= s_next_i;
         end
      end
   end

endmodule

// File: rtl/cascade_alu.sv
module cascade_alu
   import cascade_alu_pkg::*;
#(
   parameter int  SLICE_W    = 4,
   parameter int  NUM_SLICES = 4,
   localparam int DATA_W     = SLICE_W * NUM_SLICES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic              flag_en_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              zero_o,
   output logic              sign_o
);

   // Elaboration-time parameter checks
   if (SLICE_W < 1) begin : g_bad_slice_w
      $error("cascade_alu: SLICE_W must be at least 1");
   end
   if (NUM_SLICES < 1) begin : g_bad_num_slices
      $error("cascade_alu: NUM_SLICES must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("cascade_alu: data width must be at least 2 for the shifts");
   end

   alu_op_e             op;
   logic [DATA_W-1:0]   b_eff;
   logic                cin0;
   slice_fn_e           fn;
   res_sel_e            res_sel;
   logic                upd_c, upd_zs, c_next;
   logic [NUM_SLICES:0] carry_chain;
   logic [DATA_W-1:0]   slice_f;
   logic [DATA_W-1:0]   sra_v, sla_v;
   logic                sra_out, sla_out;

   assign op = alu_op_e'(op_i);

   // Operand and slice-function decode
   always_comb begin
      b_eff = reg_i;
      cin0  = 1'b0;
      fn    = FN_SUM;
      case (op)
         OP_SUB: begin b_eff = ~reg_i; cin0 = 1'b1; end
         OP_INC: begin b_eff = '0;     cin0 = 1'b1; end
         OP_DEC: b_eff = '1;
         OP_COM: fn = FN_NOT;
         OP_AND: fn = FN_AND;
         OP_OR:  fn = FN_OR;
         OP_XOR: fn = FN_XOR;
         default: ;
      endcase
   end

   // Slice cascade: carry ripples upward from slice to slice
   assign carry_chain[0] = cin0;
   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu_slice #(.W(SLICE_W)) u_slice (
         .a_i    (acc_i[s*SLICE_W +: SLICE_W]),
         .b_i    (b_eff[s*SLICE_W +: SLICE_W]),
         .cin_i  (carry_chain[s]),
         .fn_i   (fn),
         .f_o    (slice_f[s*SLICE_W +: SLICE_W]),
         .cout_o (carry_chain[s+1])
      );
   end

   alu_shift #(.DATA_W(DATA_W)) u_shift (
      .a_i       (acc_i),
      .sra_o     (sra_v),
      .sla_o     (sla_v),
      .sra_out_o (sra_out),
      .sla_out_o (sla_out)
   );

   // Result select and flag-update decode
   always_comb begin
      res_sel = SEL_SLICE;
      upd_c   = 1'b0;
      upd_zs  = 1'b0;
      c_next  = carry_chain[NUM_SLICES];
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            upd_c  = 1'b1;
            upd_zs = 1'b1;
         end
         OP_COM, OP_AND, OP_OR, OP_XOR: upd_zs = 1'b1;
         OP_SRA: begin
            res_sel = SEL_SRA;
            upd_c   = 1'b1;
            upd_zs  = 1'b1;
            c_next  = sra_out;
         end
         OP_SLA: begin
            res_sel = SEL_SLA;
            upd_c   = 1'b1;
            upd_zs  = 1'b1;
            c_next  = sla_out;
         end
         OP_STC: begin
            res_sel = SEL_PASS;
            upd_c   = 1'b1;
            c_next  = 1'b1;
         end
         OP_CLC: begin
            res_sel = SEL_PASS;
            upd_c   = 1'b1;
            c_next  = 1'b0;
         end
         default: res_sel = SEL_PASS;
      endcase
   end

   always_comb begin
      case (res_sel)
         SEL_SRA:  result_o = sra_v;
         SEL_SLA:  result_o = sla_v;
         SEL_PASS: result_o = acc_i;
         default:  result_o = slice_f;
      endcase
   end

   alu_flag_reg u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (flag_en_i),
      .upd_c_i  (upd_c),
      .upd_zs_i (upd_zs),
      .c_next_i (c_next),
      .z_next_i (~|result_o),
      .s_next_i (result_o[DATA_W-1]),
      .c_o      (carry_o),
      .z_o      (zero_o),
      .s_o      (sign_o)
   );

endmodule

// File: rtl/cascade_alu_chk.sv
module cascade_alu_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic              flag_en_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic              zero_o,
   input logic              sign_o
);

   logic is_logic_op, is_carry_cmd, is_reserved, sets_zs;
   assign is_logic_op  = (op_i >= 4'd4) && (op_i <= 4'd7);
   assign is_carry_cmd = (op_i == 4'd10) || (op_i == 4'd11);
   assign is_reserved  = (op_i >= 4'd12);
   assign sets_zs      = (op_i <= 4'd9);

   // R4: logic ops and COM keep carry
   a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && is_logic_op) |=> carry_o == $past(carry_o));

   // R5: SRA moves bit 0 into carry
   a_r5_sra_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && op_i == 4'd8) |=> carry_o == $past(acc_i[0]));

   // R6: SLA moves the top bit into carry
   a_r6_sla_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && op_i == 4'd9) |=> carry_o == $past(acc_i[DATA_W-1]));

   // R7: set and clear carry commands
   a_r7_stc: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && op_i == 4'd10) |=> carry_o);
   a_r7_clc: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && op_i == 4'd11) |=> !carry_o);
   a_r7_zs_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && is_carry_cmd) |=> $stable({zero_o, sign_o}));

   // R8: zero and sign follow the result
   a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && sets_zs) |=> zero_o == ($past(result_o) == '0));
   a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && sets_zs) |=> sign_o == $past(result_o[DATA_W-1]));

   // R9: flags hold while enable is low
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_en_i |=> $stable({carry_o, zero_o, sign_o}));

   // R10: reserved codes pass A and keep flags
   a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
      is_reserved |-> result_o == acc_i);
   a_r10_flags: assert property (@(posedge clk) disable iff (!rst_n)
      is_reserved |=> $stable({carry_o, zero_o, sign_o}));

endmodule

bind cascade_alu cascade_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .acc_i     (acc_i),
   .flag_en_i (flag_en_i),
   .result_o  (result_o),
   .carry_o   (carry_o),
   .zero_o    (zero_o),
   .sign_o    (sign_o)
);

// File: tb/sim_cascade_alu.sv
module sim_cascade_alu;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  op_i;
   logic [15:0] acc_i, reg_i, result_o;
   logic        flag_en_i, carry_o, zero_o, sign_o;

   int checks   = 0;
   int failures = 0;

   // bench flag model
   logic mc, mz, ms;

   always #5 clk = ~clk;

   cascade_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .reg_i(reg_i),
      .flag_en_i(flag_en_i), .result_o(result_o), .carry_o(carry_o),
      .zero_o(zero_o), .sign_o(sign_o)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run(string tag, logic [3:0] op, logic [15:0] a, logic [15:0] b, logic en);
      logic [16:0] w;
      logic [15:0] r;
      logic        c, upd_c, upd_zs;
      c = mc; upd_c = 1'b1; upd_zs = 1'b1; r = a;
      case (op)
         4'd0: begin w = {1'b0, a} + {1'b0, b};             r = w[15:0]; c = w[16]; end
         4'd1: begin w = {1'b0, a} + {1'b0, ~b} + 17'd1;    r = w[15:0]; c = w[16]; end
         4'd2: begin w = {1'b0, a} + 17'd1;                 r = w[15:0]; c = w[16]; end
         4'd3: begin w = {1'b0, a} + 17'h0FFFF;             r = w[15:0]; c = w[16]; end
         4'd4: begin r = ~a;    upd_c = 1'b0; end
         4'd5: begin r = a & b; upd_c = 1'b0; end
         4'd6: begin r = a | b; upd_c = 1'b0; end
         4'd7: begin r = a ^ b; upd_c = 1'b0; end
         4'd8: begin r = {a[15], a[15:1]}; c = a[0];  end
         4'd9: begin r = {a[14:0], 1'b0};  c = a[15]; end
         4'd10: begin c = 1'b1; upd_zs = 1'b0; end
         4'd11: begin c = 1'b0; upd_zs = 1'b0; end
         default: begin upd_c = 1'b0; upd_zs = 1'b0; end
      endcase
      @(negedge clk);
      op_i = op; acc_i = a; reg_i = b; flag_en_i = en;
      #1;
      chk(tag, "result", 32'(result_o), 32'(r));
      if (en) begin
         if (upd_c) mc = c;
         if (upd_zs) begin mz = (r == 16'd0); ms = r[15]; end
      end
      @(posedge clk); #1;
      chk(tag, "carry", 32'(carry_o), 32'(mc));
      chk(tag, "zero",  32'(zero_o),  32'(mz));
      chk(tag, "sign",  32'(sign_o),  32'(ms));
   endtask

   task automatic t_reset();   // R11
      rst_n = 1'b0; op_i = 4'd0; acc_i = 16'hFFFF; reg_i = 16'h0001; flag_en_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "carry", 32'(carry_o), 0);
      chk("R11", "zero",  32'(zero_o),  0);
      chk("R11", "sign",  32'(sign_o),  0);
      mc = 1'b0; mz = 1'b0; ms = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_add();
      run("R1", 4'd0, 16'h1234, 16'h4321, 1'b1);
      run("R1", 4'd0, 16'hFFFF, 16'h0001, 1'b1);  // carry through all slices, zero
      run("R1", 4'd0, 16'h0FFF, 16'h0001, 1'b1);  // inner ripple
      run("R1", 4'd0, 16'h8000, 16'h7FFF, 1'b1);  // sign
   endtask

   task automatic t_sub();
      run("R2", 4'd1, 16'h5000, 16'h1234, 1'b1);
      run("R2", 4'd1, 16'h1234, 16'h1234, 1'b1);  // equal: no borrow, zero
      run("R2", 4'd1, 16'h0001, 16'h0002, 1'b1);  // borrow
   endtask

   task automatic t_incdec();
      run("R3", 4'd2, 16'hFFFF, 16'h1111, 1'b1);
      run("R3", 4'd2, 16'h00FF, 16'h1111, 1'b1);
      run("R3", 4'd3, 16'h0000, 16'h2222, 1'b1);
      run("R3", 4'd3, 16'h0100, 16'h2222, 1'b1);
   endtask

   task automatic t_logic();
      run("R7", 4'd10, 16'h0001, 16'h0000, 1'b1); // carry = 1 first
      run("R4", 4'd5, 16'hF0F0, 16'h0FF0, 1'b1);
      run("R4", 4'd6, 16'hF000, 16'h000F, 1'b1);
      run("R4", 4'd7, 16'hAAAA, 16'hAAAA, 1'b1);
      run("R4", 4'd4, 16'h00FF, 16'h0000, 1'b1);
   endtask

   task automatic t_shift();
      run("R5", 4'd8, 16'h8001, 16'h0000, 1'b1);
      run("R5", 4'd8, 16'h4002, 16'h0000, 1'b1);
      run("R6", 4'd9, 16'h8001, 16'h0000, 1'b1);
      run("R6", 4'd9, 16'h4000, 16'h0000, 1'b1);
   endtask

   task automatic t_carry_cmd();
      run("R8", 4'd5, 16'h1234, 16'h0000, 1'b1);  // zero = 1
      run("R7", 4'd10, 16'hBEEF, 16'h0000, 1'b1);
      run("R7", 4'd11, 16'h8000, 16'h0000, 1'b1);
      run("R8", 4'd0, 16'h8000, 16'h0001, 1'b1);  // sign = 1, zero = 0
      run("R7", 4'd10, 16'h0000, 16'h0000, 1'b1);
   endtask

   task automatic t_enable();
      run("R9", 4'd0, 16'hFFFF, 16'h0001, 1'b0);
      run("R9", 4'd11, 16'h0000, 16'h0000, 1'b0);
      run("R9", 4'd9, 16'h0000, 16'h0000, 1'b0);
   endtask

   task automatic t_reserved();
      run("R10", 4'd12, 16'h0000, 16'h1111, 1'b1);
      run("R10", 4'd13, 16'h7FFF, 16'h1111, 1'b1);
      run("R10", 4'd15, 16'hFFFF, 16'h0001, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_add();
      t_sub();
      t_incdec();
      t_logic();
      t_shift();
      t_carry_cmd();
      t_enable();
      t_reserved();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule